// File: doc/BRIEF.md
# EEPROM Image Loader and Checksum Checker

This block sits between host-side logic and a serial EEPROM master. After reset, or when asked, it reads the whole 64-word image through the master into a local shadow copy. While the words arrive it keeps a running 16-bit sum. At the end it reports whether the image can be trusted. Trust requires two things: the wraparound sum must equal 0xBABA, and a signature field in word 0 must carry the expected code. If the sum is wrong, the cached word 0 is overwritten with a cleared value, so the cache stays marked untrusted.

Lookups are served from the shadow copy with no traffic on the master port. A lookup made while the cache is untrusted first reloads the image. A lookup with an out-of-range index, or one that still finds the image untrusted after the reload, answers zero. A checksum-update request re-reads words 0 to 62 and writes the balancing word into address 63. A single-word write passes one word through to the EEPROM. Either kind of write leaves the cache untrusted.

Top module: `ee_image_loader`

## Requirements
- R1: Right after reset the block loads the image by itself. It issues 64 read accesses (mem_we = 0) to addresses 0, 1, … 63 in ascending order, then pulses load_done high for one cycle.
- R2: An access holds mem_req, mem_addr, mem_we and mem_wdata steady until the cycle in which mem_ack is high. Read data is taken from mem_rdata in that ack cycle.
- R3: At the end of a load, csum_err is 1 exactly when the 16-bit wraparound sum of the 64 words differs from 0xBABA. img_valid is 1 only when the sum is 0xBABA and (word0 & 16'hC000) == 16'h4000.
- R4: When a load ends with a bad sum, the cached word 0 becomes 16'h0000, so img_valid reads 0 in the same cycle as load_done.
- R5: A lookup with index below 64, accepted while img_valid is 1, gives lk_rsp_valid one cycle later with the stored word. It makes no memory access, and ready stays high.
- R6: A lookup with index 64 or more gives lk_rsp_valid one cycle later with data 0, and makes no memory access.
- R7: A lookup with index below 64, accepted while img_valid is 0, drops ready, runs a full 64-word reload, and then answers with the word if the image is now valid, or 0 if it is not.
- R8: A checksum-update request reads words 0 to 62, then writes (0xBABA − their 16-bit sum) mod 2^16 to address 63.
- R9: A single-word write request sends wr_data to wr_addr through the master. After any write access completes, img_valid is 0.
- R10: Requests are taken only while ready is 1. A request raised while ready is 0 has no effect.
- R11: A load request reloads all 64 words even when the cache is already valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_req | input | 1 | Request a full image reload |
| upd_req | input | 1 | Request a checksum recompute and write-back |
| wr_req | input | 1 | Request a single-word write |
| wr_addr | input | 6 | Word address for a single write |
| wr_data | input | 16 | Data for a single write |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 7 | Lookup index (64 and above is out of range) |
| ready | output | 1 | Block is idle and takes a request |
| lk_rsp_valid | output | 1 | One-cycle lookup answer strobe |
| lk_rsp_data | output | 16 | Lookup answer |
| load_done | output | 1 | One-cycle pulse at the end of a load |
| img_valid | output | 1 | Cached image is trusted |
| csum_err | output | 1 | Last load found a bad sum |
| mem_req | output | 1 | Access request to the EEPROM master |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 6 | Access word address |
| mem_wdata | output | 16 | Access write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 16 | Read data, valid with mem_ack |

## Verification
The load and check path is driven with four kinds of image:
- a balanced image with a good signature, which must give a trusted cache;
- an image with one flipped bit, which separates the sum test from the signature test;
- a balanced image with a wrong signature, which shows that the signature is checked on its own;
- an unbalanced image repaired by the update request, which confirms the written word by a reload that then passes.

Lookups walk a fixed set of indices: both ends of the address range, interior words and out-of-range values. This separates cached hits, zero answers and reload-forcing misses. The memory access counts show whether a reload really took place.

// File: rtl/ee_img_pkg.sv
// Package: shared constants and the sequencer state type for the image loader.
// Assumes a 16-bit word image; other modules take these as parameter defaults.
package ee_img_pkg;
    localparam int          IMG_DW     = 16;
    localparam int          IMG_WORDS  = 64;
    localparam logic [15:0] IMG_TARGET = 16'hBABA;
    localparam logic [15:0] IMG_SMASK  = 16'hC000;
    localparam logic [15:0] IMG_SGOOD  = 16'h4000;
    localparam logic [15:0] IMG_SCLR   = 16'h0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE,
        ST_RESP
    } ldr_state_e;
endpackage

// File: rtl/ee_sum_acc.sv
// Module: running wraparound sum of words fetched from the EEPROM.
// Assumes clr and add are never high together; clr wins if they are.
module ee_sum_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] val,
    output logic [DW-1:0] sum
);
    // Accumulate modulo 2^DW; cleared at the start of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sum <= '0;
        else if (add)      sum <= sum + val;
    end

    // R3: a cleared accumulator starts the next pass from zero
    p_sum_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0));
endmodule

// File: rtl/ee_shadow_rf.sv
// Module: shadow copy of the EEPROM image with a signature check on word 0.
// Assumes SIG_CLEAR does not match SIG_VALID under SIG_MASK.
module ee_shadow_rf #(
    parameter int          DW        = 16,
    parameter int          WORDS     = 64,
    parameter logic [DW-1:0] SIG_MASK  = 16'hC000,
    parameter logic [DW-1:0] SIG_VALID = 16'h4000,
    parameter logic [DW-1:0] SIG_CLEAR = 16'h0000,
    localparam int         AW        = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          clr0,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          sig_ok
);
    logic [DW-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // One storage word; word 0 may also be forced to the cleared value.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 words[g] <= '0;
            else if ((g == 0) && clr0)                  words[g] <= SIG_CLEAR;
            else if (we && (waddr == AW'(g)))           words[g] <= wdata;
        end
    end

    // Read port and trust flag.
    always_comb begin
        rdata  = words[raddr];
        sig_ok = ((words[0] & SIG_MASK) == SIG_VALID);
    end

    // R4: clearing word 0 leaves the cache untrusted
    p_clear0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr0 |=> !sig_ok);
endmodule

// File: rtl/ee_image_loader.sv
// Module: loads the EEPROM image into a shadow copy, checks sum and signature,
// serves lookups, and writes single words or a fresh checksum word.
// Assumes the master holds mem_ack high for one cycle per access.
module ee_image_loader
    import ee_img_pkg::*;
#(
    parameter int            DW         = IMG_DW,
    parameter int            WORDS      = IMG_WORDS,
    parameter logic [DW-1:0] SUM_TARGET = IMG_TARGET,
    parameter logic [DW-1:0] SIG_MASK   = IMG_SMASK,
    parameter logic [DW-1:0] SIG_VALID  = IMG_SGOOD,
    parameter logic [DW-1:0] SIG_CLEAR  = IMG_SCLR,
    localparam int           AW         = $clog2(WORDS),
    localparam int           IW         = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_req,
    input  logic          upd_req,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          lk_req,
    input  logic [IW-1:0] lk_idx,
    output logic          ready,
    output logic          lk_rsp_valid,
    output logic [DW-1:0] lk_rsp_data,
    output logic          load_done,
    output logic          img_valid,
    output logic          csum_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [AW-1:0] LAST_LOAD = AW'(WORDS - 1);
    localparam logic [AW-1:0] LAST_UPD  = AW'(WORDS - 2);

    ldr_state_e    st;
    logic [AW-1:0] cnt;
    logic          mode_load;
    logic          lk_pend;
    logic          boot;
    logic [AW-1:0] lk_idx_q;
    logic [AW-1:0] wa_q;
    logic [DW-1:0] wbuf;
    logic [DW-1:0] sum_q;
    logic [DW-1:0] sh_rdata;
    logic          sig_ok;
    logic          idle_go, go_load, go_upd, go_wr, go_lk;
    logic          lk_in_range, lk_miss, start_rd;
    logic          sum_clr, sum_add, sh_we, sh_clr0;
    logic [AW-1:0] sh_raddr, last_idx;
    logic [DW-1:0] upd_sum;

    // Request decode and datapath controls for the current state.
    always_comb begin
        idle_go     = (st == ST_IDLE);
        go_load     = idle_go && (boot || load_req);
        go_upd      = idle_go && !go_load && upd_req;
        go_wr       = idle_go && !go_load && !upd_req && wr_req;
        go_lk       = idle_go && !go_load && !upd_req && !wr_req && lk_req;
        lk_in_range = (lk_idx < IW'(WORDS));
        lk_miss     = go_lk && lk_in_range && !sig_ok;
        start_rd    = go_load || go_upd || lk_miss;
        sum_clr     = start_rd;
        sum_add     = (st == ST_READ) && mem_ack;
        sh_we       = (st == ST_READ) && mem_ack && mode_load;
        sh_clr0     = ((st == ST_EVAL) && (sum_q != SUM_TARGET)) ||
                      ((st == ST_WRITE) && mem_ack);
        sh_raddr    = (st == ST_RESP) ? lk_idx_q : lk_idx[AW-1:0];
        last_idx    = mode_load ? LAST_LOAD : LAST_UPD;
        upd_sum     = sum_q + mem_rdata;
        mem_req     = (st == ST_READ) || (st == ST_WRITE);
        mem_we      = (st == ST_WRITE);
        mem_addr    = (st == ST_WRITE) ? wa_q : cnt;
        mem_wdata   = wbuf;
        ready       = idle_go && !boot;
        img_valid   = sig_ok;
    end

    // Sequencer: load, update, write and lookup flows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            cnt          <= '0;
            mode_load    <= 1'b1;
            lk_pend      <= 1'b0;
            boot         <= 1'b1;
            lk_idx_q     <= '0;
            wa_q         <= '0;
            wbuf         <= '0;
            lk_rsp_valid <= 1'b0;
            lk_rsp_data  <= '0;
            load_done    <= 1'b0;
            csum_err     <= 1'b0;
        end else begin
            lk_rsp_valid <= 1'b0;
            load_done    <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_rd) begin
                        st        <= ST_READ;
                        cnt       <= '0;
                        mode_load <= !go_upd;
                        lk_pend   <= lk_miss;
                        lk_idx_q  <= lk_idx[AW-1:0];
                        boot      <= 1'b0;
                    end else if (go_wr) begin
                        st   <= ST_WRITE;
                        wa_q <= wr_addr;
                        wbuf <= wr_data;
                    end else if (go_lk) begin
                        lk_rsp_valid <= 1'b1;
                        lk_rsp_data  <= lk_in_range ? sh_rdata : '0;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (cnt == last_idx) begin
                            if (mode_load) begin
                                st <= ST_EVAL;
                            end else begin
                                st   <= ST_WRITE;
                                wa_q <= LAST_LOAD;
                                wbuf <= SUM_TARGET - upd_sum;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_EVAL: begin
                    csum_err  <= (sum_q != SUM_TARGET);
                    load_done <= 1'b1;
                    st        <= lk_pend ? ST_RESP : ST_IDLE;
                end
                ST_WRITE: begin
                    if (mem_ack) st <= ST_IDLE;
                end
                ST_RESP: begin
                    lk_rsp_valid <= 1'b1;
                    lk_rsp_data  <= sig_ok ? sh_rdata : '0;
                    lk_pend      <= 1'b0;
                    st           <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    ee_sum_acc #(.DW(DW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sum_clr),
        .add   (sum_add),
        .val   (mem_rdata),
        .sum   (sum_q)
    );

    ee_shadow_rf #(
        .DW        (DW),
        .WORDS     (WORDS),
        .SIG_MASK  (SIG_MASK),
        .SIG_VALID (SIG_VALID),
        .SIG_CLEAR (SIG_CLEAR)
    ) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sh_we),
        .waddr  (cnt),
        .wdata  (mem_rdata),
        .clr0   (sh_clr0),
        .raddr  (sh_raddr),
        .rdata  (sh_rdata),
        .sig_ok (sig_ok)
    );

    // R2: an unacknowledged access keeps its request and fields steady
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R4: a load that ends with a bad sum never reports a trusted image
    p_bad_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && csum_err) |-> !img_valid);

    // R6: out-of-range lookups answer zero on the next cycle
    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && lk_req && !load_req && !upd_req && !wr_req &&
         (lk_idx >= IW'(WORDS))) |=> (lk_rsp_valid && (lk_rsp_data == '0)));

    // R7: an answer given while untrusted is zero
    p_zero_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_valid && !img_valid) |-> (lk_rsp_data == '0));

    // R9: a completed write access leaves the cache untrusted
    p_write_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> !img_valid);
endmodule

// File: tb/ee_image_loader_tb.sv
module ee_image_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0, upd_req = 1'b0, wr_req = 1'b0, lk_req = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [6:0]  lk_idx = '0;
    logic        ready, lk_rsp_valid, load_done, img_valid, csum_err;
    logic [15:0] lk_rsp_data;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;

    logic [15:0] mem [64];
    int rd_cnt = 0, wr_cnt = 0, order_err = 0, last_rd = -1;
    int checks = 0, fails = 0;

    localparam int NLK = 8;
    localparam logic [6:0] LK_TAB [NLK] = '{7'd0, 7'd1, 7'd17, 7'd42,
                                           7'd62, 7'd63, 7'd64, 7'd127};

    always #2 clk = ~clk;

    ee_image_loader u_dut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .upd_req(upd_req),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .lk_req(lk_req), .lk_idx(lk_idx), .ready(ready),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_data(lk_rsp_data),
        .load_done(load_done), .img_valid(img_valid), .csum_err(csum_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // EEPROM master model: answers each access one negedge after it appears.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) mem_ack = 1'b0;
            else if (mem_req && !mem_ack) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem[mem_addr];
                    if (int'(mem_addr) != 0 && int'(mem_addr) != last_rd + 1) order_err++;
                    last_rd = int'(mem_addr);
                    rd_cnt++;
                end
            end else mem_ack = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic fill_good();
        mem[0] = 16'h4A5A;
        for (int i = 1; i < 63; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h1357;
        mem[63] = 16'hBABA - sum_to(63);
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 1000 && !seen; i++) begin
            @(negedge clk);
            if (load_done) seen = 1'b1;
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        wait_ready();
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic lookup(input logic [6:0] idx, output logic [15:0] d, output bit got,
                          output bit rdy_after);
        wait_ready();
        lk_idx = idx;
        lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
        rdy_after = ready;
        got = lk_rsp_valid;
        for (int i = 0; i < 1000 && !got; i++) begin
            @(negedge clk);
            got = lk_rsp_valid;
        end
        d = lk_rsp_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit seen, got, rdy;
        logic [15:0] d, e;
        int r0, w0;
        fill_good();
        repeat (3) @(negedge clk);
        // Reset state
        chk(!ready && !mem_req && !load_done && !img_valid && !lk_rsp_valid && !csum_err,
            "R1 reset outputs", {ready, mem_req, img_valid}, 0);
        rst_n = 1'b1;
        // R1: automatic load after reset
        wait_done(seen);
        chk(seen, "R1 boot load_done", seen, 1);
        chk(rd_cnt == 64 && order_err == 0, "R1 boot reads ascending", rd_cnt, 64);
        chk(img_valid && !csum_err, "R3 good image trusted", {img_valid, csum_err}, 2);
        @(negedge clk);
        chk(!load_done, "R1 done is one cycle", load_done, 0);

        // R5/R6/R2: table of lookups from a trusted cache
        for (int k = 0; k < NLK; k++) begin
            r0 = rd_cnt;
            e = (LK_TAB[k] < 64) ? mem[LK_TAB[k][5:0]] : 16'h0000;
            lookup(LK_TAB[k], d, got, rdy);
            chk(got && d == e, (LK_TAB[k] < 64) ? "R5 R2 hit data" : "R6 range zero", d, e);
            chk(rd_cnt == r0 && rdy, "R5 R6 no traffic ready high", rd_cnt - r0, 0);
        end

        // R11: forced reload while valid
        r0 = rd_cnt;
        pulse(load_req);
        wait_done(seen);
        chk(seen && rd_cnt - r0 == 64, "R11 forced reload", rd_cnt - r0, 64);

        // R3/R4: one flipped bit breaks the sum
        mem[5] = mem[5] ^ 16'h0001;
        pulse(load_req);
        wait_done(seen);
        chk(seen && csum_err && !img_valid, "R4 bad sum untrusted", {csum_err, img_valid}, 2);

        // R7: lookup while untrusted reloads and still answers zero
        r0 = rd_cnt;
        lookup(7'd5, d, got, rdy);
        chk(!rdy, "R7 ready low on miss", rdy, 0);
        chk(got && d == 16'h0000 && rd_cnt - r0 == 64, "R7 miss reload zero", d, 0);

        // R3: balanced sum but wrong signature
        fill_good();
        mem[0] = 16'h8A5A;
        mem[63] = 16'hBABA - sum_to(63);
        pulse(load_req);
        wait_done(seen);
        chk(seen && !csum_err && !img_valid, "R3 bad signature", {csum_err, img_valid}, 0);

        // R8: checksum update repairs an unbalanced image
        fill_good();
        mem[63] = 16'h1234;
        mem[9] = 16'hFFFF;
        r0 = rd_cnt; w0 = wr_cnt;
        pulse(upd_req);
        @(negedge clk);
        wait_ready();
        e = 16'hBABA - sum_to(63);
        chk(mem[63] == e, "R8 written checksum", mem[63], e);
        chk(rd_cnt - r0 == 63 && wr_cnt - w0 == 1, "R8 access counts", rd_cnt - r0, 63);
        chk(!img_valid, "R9 update invalidates", img_valid, 0);
        lookup(7'd9, d, got, rdy);
        chk(got && d == 16'hFFFF && img_valid, "R7 R3 reload after update", d, 16'hFFFF);

        // R9: single write
        w0 = wr_cnt;
        wr_addr = 6'd10;
        wr_data = 16'hC0DE;
        pulse(wr_req);
        @(negedge clk);
        wait_ready();
        chk(mem[10] == 16'hC0DE && wr_cnt - w0 == 1, "R9 word written", mem[10], 16'hC0DE);
        chk(!img_valid, "R9 write invalidates", img_valid, 0);

        // R10: write request during a load is ignored
        w0 = wr_cnt;
        e = mem[20];
        pulse(load_req);
        repeat (4) @(negedge clk);
        wr_addr = 6'd20;
        wr_data = 16'hDEAD;
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        wait_done(seen);
        repeat (3) @(negedge clk);
        chk(seen && wr_cnt == w0 && mem[20] == e, "R10 busy request ignored", mem[20], e);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule